// File: doc/BRIEF.md
# Accumulator Processor with Register-Transfer Sequencing

This block is a compact single-accumulator processor. Its control unit runs every instruction as a fixed chain of single register transfers. The registers involved are a program counter, a memory address register, a memory data register, an instruction register, a 12-bit accumulator and an I/O holding register. Each control state performs exactly one transfer. The program counter advances only as the closing step of an instruction, not during fetch.

The core owns a 100-word memory. That memory is reached only through the address/data register pair, and the address register is the only source of a memory location. A program image is written through a separate load port while the core is held in reset. When reset is released, fetch starts at address 0.

Data enters through a valid/ready port. The core waits in its input state as long as the source holds valid low. When valid is high, it raises ready combinationally in that same cycle and takes the word on that clock edge. The source must keep the data stable while valid is high and ready is low. Data leaves on a one-cycle valid strobe with no back-pressure: the receiver must accept it in the strobe cycle. A halted flag reports that the halt instruction was reached.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is held, `halted`, `out_valid` and `in_ready` are low. After reset is released, execution begins with the word at address 0.
- R2: An instruction word is `{opcode[11:8], spare bit 7, address[6:0]}`. Opcode 0 (halt) performs only the three fetch transfers. `halted` rises after the third clock edge following reset release, stays high, and no output is produced afterwards.
- R3: Opcode 5 loads memory[address] into the accumulator. Opcode 9 with address 2 copies the accumulator to the I/O register and then asserts `out_valid` for exactly one cycle, with that value on `out_data`.
- R4: Opcode 1 adds memory[address] to the accumulator and opcode 2 subtracts it. Both results wrap modulo 2^12.
- R5: Opcode 3 copies the accumulator into the data register and writes it to memory[address]. A later load from that address returns the stored value.
- R6: Opcode 9 with address 1 waits without limit while `in_valid` is low, keeping `in_ready` low. `in_ready` is high for exactly one cycle, only together with `in_valid`. The accepted word reaches the accumulator.
- R7: Opcode 6 always loads the address field into the program counter.
- R8: Opcode 7 branches when the accumulator equals 0. Otherwise it falls through to the next word.
- R9: Opcode 8 branches when accumulator bit 11 is clear; zero counts as positive. Otherwise it falls through to the next word.
- R10: An address field of 100 or more selects address minus 100, for both operands and branch targets. The word after address 99 is address 0.
- R11: Cycle timing after reset release is fixed. For an output instruction at address 0, `out_valid` is high only in the cycle after the fourth clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; the load port is honoured only while this is low |
| ld_en | input | 1 | Program image write strobe |
| ld_addr | input | 7 | Program image write address (wrapped modulo 100) |
| ld_data | input | 12 | Program image write word |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken this cycle |
| in_data | input | 12 | Input word |
| out_valid | output | 1 | One-cycle strobe for an output word |
| out_data | output | 12 | Contents of the I/O register |
| halted | output | 1 | Halt instruction reached |

## Verification
A table of arithmetic operand pairs is run through the same program. Each pair ends in a zero test or a sign test, so a single program covers carries, a wrap past 0xFFF, a signed boundary at 0x7FF/0x800, a zero result, and a result that is only negative. Each pair yields two outputs: the sum or difference, and a marker that shows whether the branch was taken. An error in the arithmetic therefore shows up separately from an error in the condition. Directed programs then cover these cases:
- the exact edge on which halt and output appear;
- an input source that stays idle for a long time before offering a word;
- a store read back after the accumulator has been overwritten;
- operand addresses and branch targets above 99;
- a program counter that runs past address 99.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int DATA_W    = 12;
  localparam int ADDR_W    = 7;
  localparam int OPC_W     = 4;
  localparam int MEM_DEPTH = 100;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [OPC_W-1:0]  opc_t;

  localparam opc_t OPC_HLT = 4'd0;
  localparam opc_t OPC_ADD = 4'd1;
  localparam opc_t OPC_SUB = 4'd2;
  localparam opc_t OPC_STO = 4'd3;
  localparam opc_t OPC_LDA = 4'd5;
  localparam opc_t OPC_BRA = 4'd6;
  localparam opc_t OPC_BRZ = 4'd7;
  localparam opc_t OPC_BRP = 4'd8;
  localparam opc_t OPC_IO  = 4'd9;

  localparam addr_t IO_SEL_IN  = addr_t'(1);
  localparam addr_t IO_SEL_OUT = addr_t'(2);

  typedef enum logic [4:0] {
    ST_FMAR, ST_FMDR, ST_FIR,
    ST_OMAR, ST_RD, ST_LDA, ST_ADD, ST_SUB,
    ST_AMDR, ST_WR,
    ST_INIOR, ST_INA, ST_OUTIOR, ST_OUTV,
    ST_BR, ST_INC, ST_HALT
  } state_e;

  function automatic opc_t opc_of(word_t w);
    return w[DATA_W-1 -: OPC_W];
  endfunction

  function automatic addr_t addr_of(word_t w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic addr_t wrap_addr(addr_t a);
    return (a >= addr_t'(MEM_DEPTH)) ? addr_t'(a - addr_t'(MEM_DEPTH)) : a;
  endfunction

  function automatic addr_t step_pc(addr_t p);
    return (p == addr_t'(MEM_DEPTH - 1)) ? '0 : addr_t'(p + addr_t'(1));
  endfunction
endpackage

// File: rtl/acc_seq_mem.sv
module acc_seq_mem #(
  parameter int DW    = 12,
  parameter int AW    = 7,
  parameter int DEPTH = 100
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          a_zero,
  output logic          a_pos
);
  always_comb begin
    res    = sub ? (a - b) : (a + b);
    a_zero = (a == '0);
    a_pos  = ~a[DW-1];
  end
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  opc_t   mdr_opc,
  input  addr_t  mdr_addr,
  input  opc_t   ir_opc,
  input  logic   in_valid,
  output state_e state
);
  state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FMAR: nxt = ST_FMDR;
      ST_FMDR: nxt = ST_FIR;
      ST_FIR: begin
        case (mdr_opc)
          OPC_ADD, OPC_SUB, OPC_LDA, OPC_STO: nxt = ST_OMAR;
          OPC_BRA, OPC_BRZ, OPC_BRP:          nxt = ST_BR;
          OPC_HLT:                            nxt = ST_HALT;
          OPC_IO: begin
            if (mdr_addr == IO_SEL_IN)       nxt = ST_INIOR;
            else if (mdr_addr == IO_SEL_OUT) nxt = ST_OUTIOR;
            else                             nxt = ST_INC;
          end
          default: nxt = ST_INC;
        endcase
      end
      ST_OMAR:   nxt = (ir_opc == OPC_STO) ? ST_AMDR : ST_RD;
      ST_RD: begin
        if (ir_opc == OPC_ADD)      nxt = ST_ADD;
        else if (ir_opc == OPC_SUB) nxt = ST_SUB;
        else                        nxt = ST_LDA;
      end
      ST_LDA, ST_ADD, ST_SUB: nxt = ST_INC;
      ST_AMDR:   nxt = ST_WR;
      ST_WR:     nxt = ST_INC;
      ST_INIOR:  nxt = in_valid ? ST_INA : ST_INIOR;
      ST_INA:    nxt = ST_INC;
      ST_OUTIOR: nxt = ST_OUTV;
      ST_OUTV:   nxt = ST_INC;
      ST_BR:     nxt = ST_FMAR;
      ST_INC:    nxt = ST_FMAR;
      ST_HALT:   nxt = ST_HALT;
      default:   nxt = ST_FMAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FMAR;
    else        state <= nxt;
  end
endmodule

// File: rtl/acc_seq_dpath.sv
module acc_seq_dpath
  import acc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  state_e state,
  input  word_t  mem_rdata,
  input  logic   in_valid,
  input  word_t  in_data,
  output addr_t  pc,
  output addr_t  mar,
  output word_t  mdr,
  output opc_t   ir_opc,
  output addr_t  ir_addr,
  output word_t  ior,
  output logic   mem_we
);
  word_t acc;
  word_t alu_res;
  logic  acc_zero, acc_pos;
  logic  take;

  acc_seq_alu #(.DW(DATA_W)) alu_i (
    .a      (acc),
    .b      (mdr),
    .sub    (state == ST_SUB),
    .res    (alu_res),
    .a_zero (acc_zero),
    .a_pos  (acc_pos)
  );

  always_comb begin
    case (ir_opc)
      OPC_BRA: take = 1'b1;
      OPC_BRZ: take = acc_zero;
      OPC_BRP: take = acc_pos;
      default: take = 1'b0;
    endcase
  end

  assign mem_we = (state == ST_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      mar     <= '0;
      mdr     <= '0;
      ir_opc  <= '0;
      ir_addr <= '0;
      acc     <= '0;
      ior     <= '0;
    end else begin
      case (state)
        ST_FMAR:        mar <= pc;
        ST_FMDR, ST_RD: mdr <= mem_rdata;
        ST_FIR: begin
          ir_opc  <= opc_of(mdr);
          ir_addr <= addr_of(mdr);
        end
        ST_OMAR:        mar <= wrap_addr(ir_addr);
        ST_LDA:         acc <= mdr;
        ST_ADD, ST_SUB: acc <= alu_res;
        ST_AMDR:        mdr <= acc;
        ST_INIOR:       if (in_valid) ior <= in_data;
        ST_INA:         acc <= ior;
        ST_OUTIOR:      ior <= acc;
        ST_BR:          pc  <= take ? wrap_addr(ir_addr) : step_pc(pc);
        ST_INC:         pc  <= step_pc(pc);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              halted
);
  state_e state;
  addr_t  pc_w, mar_w, ir_addr_w;
  opc_t   ir_opc_w;
  word_t  mdr_w, ior_w, mem_rdata;
  logic   core_we;
  logic   mem_wr_en;
  addr_t  mem_wr_addr;
  word_t  mem_wr_data;

  assign mem_wr_en   = (ld_en & ~rst_n) | core_we;
  assign mem_wr_addr = rst_n ? mar_w : wrap_addr(ld_addr);
  assign mem_wr_data = rst_n ? mdr_w : ld_data;

  acc_seq_mem #(.DW(DATA_W), .AW(ADDR_W), .DEPTH(MEM_DEPTH)) mem_i (
    .clk     (clk),
    .wr_en   (mem_wr_en),
    .wr_addr (mem_wr_addr),
    .wr_data (mem_wr_data),
    .rd_addr (mar_w),
    .rd_data (mem_rdata)
  );

  acc_seq_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdr_opc  (opc_of(mdr_w)),
    .mdr_addr (addr_of(mdr_w)),
    .ir_opc   (ir_opc_w),
    .in_valid (in_valid),
    .state    (state)
  );

  acc_seq_dpath dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .mem_rdata (mem_rdata),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .pc        (pc_w),
    .mar       (mar_w),
    .mdr       (mdr_w),
    .ir_opc    (ir_opc_w),
    .ir_addr   (ir_addr_w),
    .ior       (ior_w),
    .mem_we    (core_we)
  );

  assign in_ready  = (state == ST_INIOR) & in_valid;
  assign out_valid = (state == ST_OUTV);
  assign out_data  = ior_w;
  assign halted    = (state == ST_HALT);
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
  import acc_seq_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  halted,
  input logic  out_valid,
  input logic  in_valid,
  input logic  in_ready,
  input addr_t pc,
  input addr_t mar
);
  p_halt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !out_valid);

  p_out_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_ready_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  p_mar_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mar < addr_t'(MEM_DEPTH));

  p_pc_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc < addr_t'(MEM_DEPTH));
endmodule

bind acc_seq_core acc_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .halted    (halted),
  .out_valid (out_valid),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .pc        (pc_w),
  .mar       (mar_w)
);

// File: tb/acc_seq_core_tb_top.sv
module acc_seq_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 8;
  // {a, b, sub, sign_test, expected result, expected taken}
  localparam logic [38:0] VEC [NVEC] = '{
    {12'h005, 12'h003, 1'b0, 1'b0, 12'h008, 1'b0},
    {12'h005, 12'h005, 1'b1, 1'b0, 12'h000, 1'b1},
    {12'h7FF, 12'h001, 1'b0, 1'b1, 12'h800, 1'b0},
    {12'h800, 12'h001, 1'b1, 1'b1, 12'h7FF, 1'b1},
    {12'hFFF, 12'h001, 1'b0, 1'b0, 12'h000, 1'b1},
    {12'h003, 12'h005, 1'b1, 1'b1, 12'hFFE, 1'b0},
    {12'h000, 12'h000, 1'b0, 1'b1, 12'h000, 1'b1},
    {12'h123, 12'h456, 1'b0, 1'b0, 12'h579, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [6:0]  ld_addr = '0;
  logic [11:0] ld_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_data = '0;
  logic        out_valid;
  logic [11:0] out_data;
  logic        halted;

  int errors = 0;
  int checks = 0;
  logic [11:0] img [100];
  logic [11:0] obuf [8];
  int ocnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_seq_core dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .halted(halted)
  );

  function automatic logic [11:0] enc(int opc, int addr);
    return {opc[3:0], 1'b0, addr[6:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 100; i++) img[i] = 12'h000;
  endtask

  // hold reset, write the image, release reset on a falling edge
  task automatic boot();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 7'(i); ld_data = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic run_prog(int limit);
    ocnt = 0;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (out_valid) begin
        if (ocnt < 8) obuf[ocnt] = out_data;
        ocnt++;
      end
      if (halted) break;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    clear_img();
    @(negedge clk);
    chk(!halted && !out_valid && !in_ready, "R1 reset outputs", {halted, out_valid, in_ready}, 0);

    // table walk: R3 R4 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [11:0] a, b, er;
      logic sb, sg, tk;
      {a, b, sb, sg, er, tk} = VEC[v];
      clear_img();
      img[0] = enc(5, 90);
      img[1] = enc(sb ? 2 : 1, 91);
      img[2] = enc(9, 2);
      img[3] = enc(sg ? 8 : 7, 6);
      img[4] = enc(5, 92);
      img[5] = enc(6, 7);
      img[6] = enc(5, 93);
      img[7] = enc(9, 2);
      img[8] = enc(0, 0);
      img[90] = a; img[91] = b; img[92] = 12'h111; img[93] = 12'h222;
      boot();
      run_prog(400);
      chk(ocnt == 2 && halted, "R3 output count", ocnt, 2);
      chk(obuf[0] == er, "R4 arithmetic result", obuf[0], er);
      chk(obuf[1] == (tk ? 12'h222 : 12'h111),
          sg ? "R9 sign branch" : "R8 zero branch", obuf[1], tk ? 12'h222 : 12'h111);
    end

    // R2 R11: halt timing
    clear_img();
    boot();
    @(negedge clk); @(negedge clk);
    chk(!halted, "R2 halted early", halted, 0);
    @(negedge clk);
    chk(halted, "R2 halted after third edge", halted, 1);
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (out_valid || !halted) seen++;
      end
      chk(seen == 0, "R2 halt sticky and silent", seen, 0);
    end

    // R11: output strobe timing
    clear_img();
    img[0] = enc(9, 2);
    boot();
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(!out_valid, "R11 no strobe after edge 3", out_valid, 0);
    @(negedge clk);
    chk(out_valid && out_data == 12'h000, "R11 strobe after edge 4", {out_valid, out_data}, 13'h1000);
    @(negedge clk);
    chk(!out_valid, "R11 strobe one cycle", out_valid, 0);

    // R6: input handshake with idle source
    clear_img();
    img[0] = enc(9, 1); img[1] = enc(9, 2);
    boot();
    begin
      int bad = 0, rdy = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (in_ready || out_valid || halted) bad++;
      end
      chk(bad == 0, "R6 stall while idle", bad, 0);
      in_valid = 1'b1; in_data = 12'h5A5;
      #1;
      if (in_ready) rdy++;
      @(negedge clk);
      if (in_ready) rdy++;
      in_valid = 1'b0; in_data = 12'h000;
      chk(rdy == 1, "R6 ready one cycle", rdy, 1);
    end
    run_prog(100);
    chk(ocnt == 1 && obuf[0] == 12'h5A5, "R6 input reaches accumulator", obuf[0], 12'h5A5);

    // R5: store then reload
    clear_img();
    img[0] = enc(5, 90); img[1] = enc(3, 95); img[2] = enc(5, 91);
    img[3] = enc(9, 2);  img[4] = enc(5, 95); img[5] = enc(9, 2);
    img[90] = 12'h321; img[91] = 12'h0AB;
    boot();
    run_prog(400);
    chk(ocnt == 2 && obuf[0] == 12'h0AB, "R5 accumulator overwritten", obuf[0], 12'h0AB);
    chk(obuf[1] == 12'h321, "R5 stored word read back", obuf[1], 12'h321);

    // R10 R7: operand and target above 99
    clear_img();
    img[0] = enc(5, 105); img[1] = enc(9, 2); img[2] = enc(6, 103);
    img[3] = enc(0, 0);   img[4] = enc(9, 2); img[5] = 12'h3C3;
    boot();
    run_prog(400);
    chk(ocnt == 1 && obuf[0] == 12'h3C3 && halted, "R10 address wrap", obuf[0], 12'h3C3);

    // R10 R8: program counter past 99
    clear_img();
    img[0] = enc(7, 2); img[1] = enc(0, 0); img[2] = enc(5, 97);
    img[3] = enc(6, 99); img[99] = enc(9, 2); img[97] = 12'h077;
    boot();
    run_prog(400);
    chk(ocnt == 1 && obuf[0] == 12'h077 && halted, "R10 pc wrap to 0", obuf[0], 12'h077);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule